// File: doc/BRIEF.md
# Calibration section locator and checker

This block scans a stream of bytes read one after another from a configuration EEPROM and looks for the four-byte marker 0xDE 0xAD 0xBE 0xEF that opens a calibration section. It reads the 16-bit entry count that follows the marker and reports where the entry list begins. A count of zero, or a scan that reaches the end of the memory, gives a not-found result. The count is limited to a parameter value, and a flag shows when that limit was applied.

A second run, in verify mode, takes in the entry bytes (28 per entry) and then one checksum byte. It reports pass or fail. The expected checksum is the low 8 bits of the sum of the two count bytes and every entry byte. The bytes themselves come from an I2C master outside this block. Matching of part numbers is done elsewhere.

Each run begins with a one-cycle `start_i` pulse that also selects the mode. The block counts its own byte index, which is 0 for the first byte accepted after a locate start.

Top module: `cal_section_scan`

## Requirements
- R1: After reset, busy_o, done_o, found_o, not_found_o, clamp_o, csum_ok_o and csum_err_o are all 0.
- R2: In locate mode (start_i with mode_i=0), only bytes with vld_i=1 are taken. Bytes are indexed from 0. The marker is recognised only as 0xDE, 0xAD, 0xBE, 0xEF in that order.
- R3: A byte that breaks a partial marker restarts matching, and that same byte is tested as a possible first marker byte 0xDE. For example, DE DE AD BE EF is recognised.
- R4: The two bytes after the marker form the count, high byte first. After the second count byte, found_o=1, done_o=1, and start_addr_o is the index of the next byte. All of these are visible in the cycle after that byte is taken.
- R5: A count of 0 gives not_found_o=1 and done_o=1, with found_o=0.
- R6: If the byte at index MEM_BYTES-1 is taken and does not complete a section, the result is not_found_o=1 and done_o=1. A section whose second count byte is at that index still counts as found, with start_addr_o=MEM_BYTES.
- R7: A count above MAX_ENTRIES sets clamp_o=1 and count_o=MAX_ENTRIES. Otherwise count_o equals the count and clamp_o=0.
- R8: In verify mode (start_i with mode_i=1) after a found result, the block takes count_o*ENTRY_BYTES entry bytes and then one checksum byte. csum_ok_o=1 if that byte equals the low 8 bits of (count high byte + count low byte + all entry bytes). Otherwise csum_err_o=1. done_o=1 in either case.
- R9: A verify start while found_o=0 gives done_o=1 and csum_err_o=1 in the next cycle, and takes no bytes.
- R10: While done_o=1, bytes on the input are ignored, and every result output keeps its value until the next start_i.
- R11: A verify start keeps found_o, start_addr_o, count_o and clamp_o. A locate start clears all results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that starts a run |
| mode_i | input | 1 | Mode sampled with start_i: 0 locate, 1 verify |
| vld_i | input | 1 | data_i carries a byte this cycle |
| data_i | input | 8 | Byte from the EEPROM stream |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | The last run has finished |
| found_o | output | 1 | A section with a nonzero count was located |
| not_found_o | output | 1 | No usable section was located |
| start_addr_o | output | AW | Byte index of the first entry byte |
| count_o | output | 16 | Entry count after limiting |
| clamp_o | output | 1 | The count read was above MAX_ENTRIES |
| csum_ok_o | output | 1 | The checksum byte matched |
| csum_err_o | output | 1 | The checksum byte did not match, or verify was started with no section |

## Verification
The bench aims at three kinds of corner case. The first is a marker broken partway and restarted on the same byte: a matcher that drops the breaking byte would miss a DE DE AD BE EF run. The second is a marker placed so close to the end of memory that its count either just fits or just fails to fit: an off-by-one end check would report the wrong result. The third is a count whose high byte is nonzero, or that is zero: a design that swaps the count bytes would produce a wrong count and a wrong clamp. Checksum runs cover limited counts, corrupted checksum bytes and verify with no section, where a design that leaves out the count bytes from the sum, or runs for the wrong number of bytes, would report the wrong status.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam logic [31:0] SECT_MARKER = 32'hDEAD_BEEF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_CNT_HI,
    ST_CNT_LO,
    ST_ENTRY,
    ST_DONE
  } cal_state_e;
endpackage

// File: rtl/cal_marker_match.sv
module cal_marker_match #(
  parameter logic [31:0] PATTERN = 32'hDEAD_BEEF,
  parameter int          NBYTES  = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic [7:0] data_i,
  output logic       hit_o
);
  localparam int SW = $clog2(NBYTES);

  logic [7:0]    pat_b [NBYTES];
  logic [SW-1:0] stage_q;

  for (genvar g = 0; g < NBYTES; g++) begin : g_pat
    assign pat_b[g] = PATTERN[8*(NBYTES-1-g) +: 8];
  end

  assign hit_o = en_i && (stage_q == SW'(NBYTES-1)) && (data_i == pat_b[NBYTES-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else if (clr_i) begin
      stage_q <= '0;
    end else if (en_i) begin
      if (hit_o)                          stage_q <= '0;
      else if (data_i == pat_b[stage_q])  stage_q <= stage_q + SW'(1);
      else if (data_i == pat_b[0])        stage_q <= SW'(1);  // breaking byte retried as first
      else                                stage_q <= '0;
    end
  end
endmodule

// File: rtl/cal_sum_acc.sv
module cal_sum_acc #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] seed_i,
  input  logic         add_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] sum_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sum_o <= '0;
    else if (clr_i)  sum_o <= seed_i;
    else if (add_i)  sum_o <= sum_o + data_i;
  end
endmodule

// File: rtl/cal_section_scan.sv
module cal_section_scan
  import cal_pkg::*;
#(
  parameter int MEM_BYTES   = 65536,
  parameter int MAX_ENTRIES = 8,
  parameter int ENTRY_BYTES = 28,
  localparam int AW = $clog2(MEM_BYTES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic          vld_i,
  input  logic [7:0]    data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          found_o,
  output logic          not_found_o,
  output logic [AW-1:0] start_addr_o,
  output logic [15:0]   count_o,
  output logic          clamp_o,
  output logic          csum_ok_o,
  output logic          csum_err_o
);
  localparam int RW = $clog2(MAX_ENTRIES * ENTRY_BYTES + 1);

  cal_state_e    state_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    cnt_hi_q, cnt_lo_q;
  logic [RW-1:0] rem_q;
  logic          take, last_byte, hit, sum_clr, sum_add;
  logic [7:0]    sum;
  logic [15:0]   raw_cnt;

  assign take      = vld_i && !start_i;
  assign last_byte = (addr_q == AW'(MEM_BYTES - 1));
  assign raw_cnt   = {cnt_hi_q, data_i};
  assign sum_clr   = start_i && mode_i && found_o;
  assign sum_add   = take && (state_q == ST_ENTRY) && (rem_q != '0);
  assign busy_o    = (state_q != ST_IDLE) && (state_q != ST_DONE);

  cal_marker_match #(.PATTERN(SECT_MARKER), .NBYTES(4)) u_match (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .en_i   (take && (state_q == ST_SCAN)),
    .data_i (data_i),
    .hit_o  (hit)
  );

  cal_sum_acc #(.W(8)) u_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sum_clr),
    .seed_i (cnt_hi_q + cnt_lo_q),
    .add_i  (sum_add),
    .data_i (data_i),
    .sum_o  (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      cnt_hi_q     <= '0;
      cnt_lo_q     <= '0;
      rem_q        <= '0;
      done_o       <= 1'b0;
      found_o      <= 1'b0;
      not_found_o  <= 1'b0;
      start_addr_o <= '0;
      count_o      <= '0;
      clamp_o      <= 1'b0;
      csum_ok_o    <= 1'b0;
      csum_err_o   <= 1'b0;
    end else if (start_i) begin
      done_o     <= 1'b0;
      csum_ok_o  <= 1'b0;
      csum_err_o <= 1'b0;
      if (!mode_i) begin
        state_q      <= ST_SCAN;
        addr_q       <= '0;
        found_o      <= 1'b0;
        not_found_o  <= 1'b0;
        start_addr_o <= '0;
        count_o      <= '0;
        clamp_o      <= 1'b0;
      end else if (found_o) begin
        state_q <= ST_ENTRY;
        rem_q   <= RW'(32'(count_o) * ENTRY_BYTES);
      end else begin
        state_q    <= ST_DONE;
        done_o     <= 1'b1;
        csum_err_o <= 1'b1;
      end
    end else if (take) begin
      unique case (state_q)
        ST_SCAN: begin
          addr_q <= addr_q + AW'(1);
          if (last_byte) begin
            state_q     <= ST_DONE;
            not_found_o <= 1'b1;
            done_o      <= 1'b1;
          end else if (hit) begin
            state_q <= ST_CNT_HI;
          end
        end
        ST_CNT_HI: begin
          addr_q   <= addr_q + AW'(1);
          cnt_hi_q <= data_i;
          if (last_byte) begin
            state_q     <= ST_DONE;
            not_found_o <= 1'b1;
            done_o      <= 1'b1;
          end else begin
            state_q <= ST_CNT_LO;
          end
        end
        ST_CNT_LO: begin
          addr_q   <= addr_q + AW'(1);
          cnt_lo_q <= data_i;
          state_q  <= ST_DONE;
          done_o   <= 1'b1;
          if (raw_cnt == 16'd0) begin
            not_found_o <= 1'b1;
          end else begin
            found_o      <= 1'b1;
            start_addr_o <= addr_q + AW'(1);
            if (32'(raw_cnt) > MAX_ENTRIES) begin
              count_o <= 16'(MAX_ENTRIES);
              clamp_o <= 1'b1;
            end else begin
              count_o <= raw_cnt;
            end
          end
        end
        ST_ENTRY: begin
          if (rem_q != '0) begin
            rem_q <= rem_q - RW'(1);
          end else begin
            state_q    <= ST_DONE;
            done_o     <= 1'b1;
            csum_ok_o  <= (data_i == sum);
            csum_err_o <= (data_i != sum);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cal_section_scan_chk.sv
module cal_section_scan_chk #(
  parameter int MEM_BYTES   = 65536,
  parameter int MAX_ENTRIES = 8,
  parameter int AW          = 17
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          vld_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          found_o,
  input logic          not_found_o,
  input logic [AW-1:0] start_addr_o,
  input logic [15:0]   count_o,
  input logic          clamp_o,
  input logic          csum_ok_o,
  input logic          csum_err_o
);
  a_r5_found_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(found_o && not_found_o));

  a_r8_csum_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(csum_ok_o && csum_err_o));

  a_r7_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> (count_o != 16'd0) && (32'(count_o) <= MAX_ENTRIES)
                && (!clamp_o || 32'(count_o) == MAX_ENTRIES));

  a_r4_addr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> (32'(start_addr_o) >= 6) && (32'(start_addr_o) <= MEM_BYTES));

  a_r4_found_on_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(found_o) |-> $past(vld_i) && $past(busy_o));

  a_r8_ok_on_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(csum_ok_o) |-> $past(vld_i) && $past(busy_o));

  a_r10_results_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o && !busy_o && $stable(found_o) && $stable(not_found_o)
      && $stable(count_o) && $stable(start_addr_o) && $stable(csum_ok_o) && $stable(csum_err_o));
endmodule

bind cal_section_scan cal_section_scan_chk #(
  .MEM_BYTES(MEM_BYTES), .MAX_ENTRIES(MAX_ENTRIES), .AW(AW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .vld_i(vld_i),
  .busy_o(busy_o), .done_o(done_o), .found_o(found_o), .not_found_o(not_found_o),
  .start_addr_o(start_addr_o), .count_o(count_o), .clamp_o(clamp_o),
  .csum_ok_o(csum_ok_o), .csum_err_o(csum_err_o)
);

// File: tb/cal_section_scan_test.sv
module cal_section_scan_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEM  = 200;
  localparam int MAXE = 3;
  localparam int EB   = 28;
  localparam int AW   = $clog2(MEM + 1);

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, mode_i = 1'b0, vld_i = 1'b0;
  logic [7:0] data_i = '0;
  logic busy_o, done_o, found_o, not_found_o, clamp_o, csum_ok_o, csum_err_o;
  logic [AW-1:0] start_addr_o;
  logic [15:0] count_o;

  int checks = 0, errors = 0;
  logic [7:0] img [MEM];
  bit e_found, e_clamp;
  int e_addr, e_cnt;
  logic [7:0] e_hi, e_lo;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_section_scan #(.MEM_BYTES(MEM), .MAX_ENTRIES(MAXE), .ENTRY_BYTES(EB)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i), .vld_i(vld_i),
    .data_i(data_i), .busy_o(busy_o), .done_o(done_o), .found_o(found_o),
    .not_found_o(not_found_o), .start_addr_o(start_addr_o), .count_o(count_o),
    .clamp_o(clamp_o), .csum_ok_o(csum_ok_o), .csum_err_o(csum_err_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    if ($urandom % 4 == 0) begin vld_i = 1'b0; @(negedge clk); end
    vld_i = 1'b1; data_i = b;
    @(negedge clk);
    vld_i = 1'b0;
  endtask

  task automatic pulse_start(input bit m);
    start_i = 1'b1; mode_i = m;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic fill(input logic [7:0] v);
    for (int i = 0; i < MEM; i++) img[i] = v;
  endtask

  task automatic put_section(input int pos, input logic [7:0] hi, input logic [7:0] lo);
    img[pos] = 8'hDE; img[pos+1] = 8'hAD; img[pos+2] = 8'hBE; img[pos+3] = 8'hEF;
    if (pos + 4 < MEM) img[pos+4] = hi;
    if (pos + 5 < MEM) img[pos+5] = lo;
  endtask

  // expected result: first occurrence of the marker, count must fit in memory
  task automatic model;
    int p = -1;
    e_found = 0; e_clamp = 0; e_addr = 0; e_cnt = 0;
    for (int i = 0; i + 3 < MEM; i++)
      if (img[i] == 8'hDE && img[i+1] == 8'hAD && img[i+2] == 8'hBE && img[i+3] == 8'hEF) begin
        p = i; break;
      end
    if (p >= 0 && p + 5 < MEM) begin
      e_hi = img[p+4]; e_lo = img[p+5];
      if ({e_hi, e_lo} != 16'd0) begin
        e_found = 1; e_addr = p + 6;
        e_cnt = {e_hi, e_lo};
        if (e_cnt > MAXE) begin e_cnt = MAXE; e_clamp = 1; end
      end
    end
  endtask

  task automatic run_locate(input string tag);
    pulse_start(1'b0);
    for (int i = 0; i < MEM && !done_o; i++) send_byte(img[i]);
    model();
    chk({tag, " R4 done"}, done_o, 1);
    chk({tag, " R2 found"}, found_o, e_found);
    chk({tag, " R5 R6 not_found"}, not_found_o, !e_found);
    if (e_found) begin
      chk({tag, " R4 start_addr"}, start_addr_o, e_addr);
      chk({tag, " R7 count"}, count_o, e_cnt);
      chk({tag, " R7 clamp"}, clamp_o, e_clamp);
    end
  endtask

  task automatic run_verify(input string tag, input bit good);
    logic [7:0] s = e_hi + e_lo;
    logic [7:0] b;
    pulse_start(1'b1);
    chk({tag, " R8 busy"}, busy_o, 1);
    for (int i = 0; i < e_cnt * EB; i++) begin
      b = 8'($urandom); s = s + b; send_byte(b);
    end
    chk({tag, " R8 not done before checksum"}, done_o, 0);
    send_byte(good ? s : s + 8'd1);
    chk({tag, " R8 done"}, done_o, 1);
    chk({tag, " R8 ok"}, csum_ok_o, good);
    chk({tag, " R8 err"}, csum_err_o, !good);
    chk({tag, " R11 found kept"}, found_o, 1);
    chk({tag, " R11 count kept"}, count_o, e_cnt);
    chk({tag, " R11 addr kept"}, start_addr_o, e_addr);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 busy", busy_o, 0);  chk("R1 done", done_o, 0);
    chk("R1 found", found_o, 0); chk("R1 not_found", not_found_o, 0);
    chk("R1 clamp", clamp_o, 0); chk("R1 ok", csum_ok_o, 0); chk("R1 err", csum_err_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R9: verify without a found section
    pulse_start(1'b1);
    chk("R9 done", done_o, 1); chk("R9 err", csum_err_o, 1); chk("R9 ok", csum_ok_o, 0);

    // R2 R4: marker at 0, count 2
    fill(8'h11); put_section(0, 8'h00, 8'h02);
    run_locate("d0"); chk("R4 addr 6", start_addr_o, 6);
    run_verify("d0", 1);
    run_verify("d0b", 0);

    // R10: bytes after done are ignored
    send_byte(8'hDE); send_byte(8'hAD); send_byte(8'h00);
    chk("R10 done kept", done_o, 1); chk("R10 err kept", csum_err_o, 1);
    chk("R10 count kept", count_o, 2);

    // R3: breaking byte retried as first marker byte
    fill(8'h22); img[10] = 8'hDE; put_section(11, 8'h00, 8'h01);
    run_locate("d1"); chk("R3 addr", start_addr_o, 17);
    fill(8'h22); img[20] = 8'hDE; img[21] = 8'hAD; img[22] = 8'hBE; img[23] = 8'h00;
    img[40] = 8'hDE; img[41] = 8'hAD; put_section(42, 8'h00, 8'h03);
    run_locate("d2"); chk("R3 addr2", start_addr_o, 48);
    // R2: out-of-order marker bytes not accepted
    fill(8'h33); img[5] = 8'hAD; img[6] = 8'hDE; img[7] = 8'hBE; img[8] = 8'hEF;
    img[9] = 8'h00; img[10] = 8'h01;
    run_locate("d3"); chk("R2 wrong order", found_o, 0);

    // R5: zero count
    fill(8'h44); put_section(30, 8'h00, 8'h00);
    run_locate("d4"); chk("R5 zero count nf", not_found_o, 1);

    // R6: no marker, and end-of-memory edges
    fill(8'h55); run_locate("d5"); chk("R6 nf", not_found_o, 1);
    fill(8'h55); put_section(MEM - 6, 8'h00, 8'h01);
    run_locate("d6"); chk("R6 addr at end", start_addr_o, MEM);
    fill(8'h55); put_section(MEM - 5, 8'h00, 8'h01);
    run_locate("d7"); chk("R6 count cut off", not_found_o, 1);

    // R7: big-endian count and clamping
    fill(8'h66); put_section(7, 8'h02, 8'h00);
    run_locate("d8"); chk("R7 clamp 512", clamp_o, 1); chk("R7 count max", count_o, MAXE);
    run_verify("d8", 1);
    fill(8'h66); put_section(7, 8'h00, 8'h03);
    run_locate("d9"); chk("R7 no clamp at max", clamp_o, 0);

    // R11: locate start clears verify results
    pulse_start(1'b0);
    chk("R11 ok cleared", csum_ok_o, 0); chk("R11 found cleared", found_o, 0);
    chk("R11 busy", busy_o, 1);
    for (int i = 0; i < MEM && !done_o; i++) send_byte(8'h00);

    // constrained random
    for (int it = 0; it < 24; it++) begin
      for (int i = 0; i < MEM; i++) img[i] = 8'($urandom);
      if ($urandom % 4 != 0)
        put_section($urandom % (MEM - 3), ($urandom % 3 == 0) ? 8'($urandom) : 8'h00,
                    8'($urandom % 6));
      run_locate("rnd");
      if (e_found) run_verify("rnd", ($urandom % 2) == 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule